// File: doc/BRIEF.md
# Interprocessor and interval-timer interrupt register

This block holds one 64-bit control word that raises and clears interprocessor interrupts and interval-timer interrupts for up to four processors. It also holds one ignore counter per processor. The counters thin out a shared timer tick. Software reaches the control word and the counters over a simple register bus with full 64-bit accesses. Each field of the control word reacts to a write in its own way. Some bits clear when written with 1, some set when written with 1, one nibble is a lock that can only be loaded while it is zero, one bit wipes a whole byte, and one nibble is ordinary storage.

On every rising edge of the tick input, each present processor's counter counts down by one. The counter carries a sticky overflow bit. While that bit is set, each tick sets the processor's timer-interrupt bit. That bit, and the interrupt it drives, stay high until software clears the bit. Reads of the control word carry the 2-bit index of the reading processor in the two lowest bits. A processor marked absent sees its interrupt outputs held low, and its counter does not move with the tick.

Top module: `irq_misc_reg`

## Requirements
- R1: After synchronous reset the control word holds 0x0000_0008_0000_0000 (bit 35 set), every counter holds zero and all interrupt outputs are low.
- R2: A read of word address 0 returns the control word with `rd_cpu` ORed into bits 1:0. Reads of addresses that are neither 0 nor 8..11 return zero, and writes to them change no state.
- R3: A control write clears each control bit where the write data has a 1 inside mask 0x1000_0FF0 (timer bits 7:4, interprocessor bits 11:8, bit 28).
- R4: A control write with data bit 20 set clears control bits 23:16. With data bit 20 clear, data bits 23:20 are ORed into control bits 23:20.
- R5: With data bit 20 clear, data bits 19:16 are loaded into control bits 19:16 only if those bits are all zero before the write. Otherwise they keep their value.
- R6: Data bits 15:12 of a control write set control bits 11:8. A set request wins over a clear of the same bit in the same write. `ipi_irq[i]` equals control bit 8+i.
- R7: Control bits 43:40 take write data bits 43:40. All other control bits not named in R3 to R6 keep their value through a write.
- R8: A write to address 8+i loads counter i with data bits 23:0 and clears its overflow bit 24. A read of address 8+i returns the 25-bit counter zero-extended.
- R9: On each rising edge of `tick`, the counter of each present processor becomes (value - 1) mod 2^25, ORed with its previous bit 24. A tick held high or falling changes nothing.
- R10: If a counter's bit 24 is set after that step, control bit 4+i is set. `timer_irq[i]` equals control bit 4+i and falls only through an R3 clear.
- R11: When a tick edge and a write fall in the same cycle, the tick effect is applied first and the write is applied to the result.
- R12: While `cpu_present[i]` is low, `ipi_irq[i]` and `timer_irq[i]` are low, counter i does not step, and ticks do not set control bit 4+i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe for one 64-bit write |
| bus_addr | input | 4 | Word address: 0 control, 8+i counter i |
| bus_wdata | input | 64 | Write data |
| rd_cpu | input | 2 | Index of the processor issuing the read |
| bus_rdata | output | 64 | Read data, combinational from `bus_addr` |
| tick | input | 1 | Interval-timer tick level; rising edges count |
| cpu_present | input | 4 | Processor present flags |
| ipi_irq | output | 4 | Interprocessor interrupt per processor |
| timer_irq | output | 4 | Interval-timer interrupt per processor |

## Verification
A wrong bit in the control word shows up at the interrupt outputs one cycle after the write or tick that caused it. It shows on the next read of address 0 at once, so every check reads the whole state right after each cycle. A wrong counter value can stay hidden for many ticks, until the overflow bit decides whether a timer interrupt appears. For that reason the counters are read back after every tick, and small start values are used so that overflow is reached within a few edges. The lock nibble is swept over every pair of old and new values, because a wrong gate on it only shows when the old value is non-zero.

// File: rtl/irq_misc_pkg.sv
`timescale 1ns/1ps
package irq_misc_pkg;

    localparam int WORD_W   = 64;
    localparam int NIB_W    = 4;
    localparam int TMR_LSB  = 4;
    localparam int IPI_LSB  = 8;
    localparam int REQ_LSB  = 12;
    localparam int LOCK_LSB = 16;
    localparam int HOLD_LSB = 20;
    localparam int WIPE_BIT = 20;
    localparam int USER_LSB = 40;

    localparam logic [WORD_W-1:0] CLR_MASK  = 64'h0000_0000_1000_0FF0;
    localparam logic [WORD_W-1:0] RESET_VAL = 64'h0000_0008_0000_0000;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_CNT
    } sel_t;

    typedef struct packed {
        logic              en;
        logic [WORD_W-1:0] data;
    } wr_req_t;

    // Field-by-field merge of one write into the control word.
    function automatic logic [WORD_W-1:0] ctrl_merge(
        input logic [WORD_W-1:0] cur,
        input logic [WORD_W-1:0] wd
    );
        logic [WORD_W-1:0] n;
        n = cur & ~(wd & CLR_MASK);
        if (wd[WIPE_BIT]) begin
            n[HOLD_LSB+NIB_W-1:LOCK_LSB] = '0;
        end else begin
            n[HOLD_LSB +: NIB_W] = n[HOLD_LSB +: NIB_W] | wd[HOLD_LSB +: NIB_W];
            if (n[LOCK_LSB +: NIB_W] == '0) begin
                n[LOCK_LSB +: NIB_W] = wd[LOCK_LSB +: NIB_W];
            end
        end
        n[IPI_LSB +: NIB_W]  = n[IPI_LSB +: NIB_W] | wd[REQ_LSB +: NIB_W];
        n[USER_LSB +: NIB_W] = wd[USER_LSB +: NIB_W];
        return n;
    endfunction

endpackage

// File: rtl/irq_tick_edge.sv
`timescale 1ns/1ps
module irq_tick_edge (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic tick_rise
);
    logic tick_q;

    always_ff @(posedge clk) begin
        if (rst) tick_q <= 1'b0;
        else     tick_q <= tick;
    end

    assign tick_rise = tick & ~tick_q;
endmodule

// File: rtl/irq_ignore_cnt.sv
`timescale 1ns/1ps
module irq_ignore_cnt #(
    parameter int CNT_W = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             present,
    input  logic             tick_rise,
    input  logic             wr_en,
    input  logic [CNT_W-2:0] wr_val,
    output logic [CNT_W-1:0] cnt_q,
    output logic             fire
);
    localparam int OVF = CNT_W - 1;

    logic [CNT_W-1:0] stepped;
    logic [CNT_W-1:0] cnt_d;
    logic             step_en;

    always_comb begin
        step_en      = tick_rise & present;
        stepped      = cnt_q - CNT_W'(1);
        stepped[OVF] = stepped[OVF] | cnt_q[OVF];
        fire         = step_en & stepped[OVF];
        cnt_d        = cnt_q;
        if (step_en) cnt_d = stepped;
        // write lands after the tick step
        if (wr_en)   cnt_d = {1'b0, wr_val};
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/irq_misc_ctrl.sv
`timescale 1ns/1ps
module irq_misc_ctrl
    import irq_misc_pkg::*;
#(
    parameter int NCPU = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  wr_req_t           req,
    input  logic [NCPU-1:0]   fire,
    output logic [WORD_W-1:0] ctrl_q
);
    logic [WORD_W-1:0] after_tick;
    logic [WORD_W-1:0] ctrl_d;

    always_comb begin
        after_tick = ctrl_q;
        for (int i = 0; i < NCPU; i++) begin
            after_tick[TMR_LSB+i] = ctrl_q[TMR_LSB+i] | fire[i];
        end
        ctrl_d = req.en ? ctrl_merge(after_tick, req.data) : after_tick;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= RESET_VAL;
        else     ctrl_q <= ctrl_d;
    end
endmodule

// File: rtl/irq_read_mux.sv
`timescale 1ns/1ps
module irq_read_mux
    import irq_misc_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int CNT_W     = 25,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int CNT_BASE  = 8
) (
    input  logic [ADDR_W-1:0]          addr,
    input  logic [1:0]                 rd_cpu,
    input  logic [WORD_W-1:0]          ctrl_q,
    input  logic [NCPU-1:0][CNT_W-1:0] cnts,
    output logic [WORD_W-1:0]          rdata
);
    sel_t                  sel;
    logic [$clog2(NCPU+1)-1:0] idx;

    always_comb begin
        sel = SEL_NONE;
        idx = '0;
        if (addr == ADDR_W'(CTRL_ADDR)) sel = SEL_CTRL;
        for (int i = 0; i < NCPU; i++) begin
            if (addr == ADDR_W'(CNT_BASE + i)) begin
                sel = SEL_CNT;
                idx = ($clog2(NCPU+1))'(i);
            end
        end
    end

    always_comb begin
        unique case (sel)
            SEL_CTRL: rdata = ctrl_q | WORD_W'(rd_cpu);
            SEL_CNT:  rdata = WORD_W'(cnts[idx]);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/irq_misc_reg.sv
`timescale 1ns/1ps
module irq_misc_reg
    import irq_misc_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int CNT_W     = 25,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int CNT_BASE  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [63:0]       bus_wdata,
    input  logic [1:0]        rd_cpu,
    output logic [63:0]       bus_rdata,
    input  logic              tick,
    input  logic [NCPU-1:0]   cpu_present,
    output logic [NCPU-1:0]   ipi_irq,
    output logic [NCPU-1:0]   timer_irq
);
    logic                     tick_rise;
    logic [NCPU-1:0]          fire;
    logic [NCPU-1:0]          wr_cnt;
    logic [NCPU-1:0][CNT_W-1:0] cnt_all;
    logic [WORD_W-1:0]        ctrl_q;
    wr_req_t                  ctrl_req;

    irq_tick_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .tick_rise (tick_rise)
    );

    for (genvar i = 0; i < NCPU; i++) begin : g_cnt
        assign wr_cnt[i] = bus_wr && (bus_addr == ADDR_W'(CNT_BASE + i));

        irq_ignore_cnt #(.CNT_W(CNT_W)) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .present   (cpu_present[i]),
            .tick_rise (tick_rise),
            .wr_en     (wr_cnt[i]),
            .wr_val    (bus_wdata[CNT_W-2:0]),
            .cnt_q     (cnt_all[i]),
            .fire      (fire[i])
        );
    end

    assign ctrl_req.en   = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
    assign ctrl_req.data = bus_wdata;

    irq_misc_ctrl #(.NCPU(NCPU)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req    (ctrl_req),
        .fire   (fire),
        .ctrl_q (ctrl_q)
    );

    irq_read_mux #(
        .NCPU      (NCPU),
        .CNT_W     (CNT_W),
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .CNT_BASE  (CNT_BASE)
    ) u_rd (
        .addr   (bus_addr),
        .rd_cpu (rd_cpu),
        .ctrl_q (ctrl_q),
        .cnts   (cnt_all),
        .rdata  (bus_rdata)
    );

    assign ipi_irq   = ctrl_q[IPI_LSB +: NCPU] & cpu_present;
    assign timer_irq = ctrl_q[TMR_LSB +: NCPU] & cpu_present;
endmodule

// File: rtl/irq_misc_chk.sv
`timescale 1ns/1ps
module irq_misc_chk
    import irq_misc_pkg::*;
#(
    parameter int NCPU      = 4,
    parameter int CNT_W     = 25,
    parameter int ADDR_W    = 4,
    parameter int CTRL_ADDR = 0,
    parameter int CNT_BASE  = 8
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     bus_wr,
    input logic [ADDR_W-1:0]        bus_addr,
    input logic [63:0]              bus_wdata,
    input logic [1:0]               rd_cpu,
    input logic [63:0]              bus_rdata,
    input logic [NCPU-1:0]          cpu_present,
    input logic [NCPU-1:0]          ipi_irq,
    input logic [NCPU-1:0]          timer_irq,
    input logic [WORD_W-1:0]        ctrl_q,
    input logic [NCPU-1:0][CNT_W-1:0] cnt_all
);
    logic ctrl_wr;
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));

    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> ctrl_q == RESET_VAL); // R1

    AST_READ_INDEX: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_W'(CTRL_ADDR)) |-> bus_rdata[1:0] == rd_cpu); // R2

    AST_LOCK_HELD: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[LOCK_LSB +: NIB_W] != '0 && !(ctrl_wr && bus_wdata[WIPE_BIT]))
        |=> $stable(ctrl_q[LOCK_LSB +: NIB_W])); // R5

    AST_IPI_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q[IPI_LSB +: NIB_W])); // R6

    AST_USER_STABLE: assert property (@(posedge clk) disable iff (rst)
        !ctrl_wr |=> $stable(ctrl_q[USER_LSB +: NIB_W])); // R7

    for (genvar i = 0; i < NCPU; i++) begin : g_cpu
        logic cnt_wr;
        assign cnt_wr = bus_wr && (bus_addr == ADDR_W'(CNT_BASE + i));

        AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
            (cnt_all[i][CNT_W-1] && !cnt_wr) |=> cnt_all[i][CNT_W-1]); // R9

        AST_TIMER_DROP: assert property (@(posedge clk) disable iff (rst)
            $fell(timer_irq[i]) |->
                ($past(ctrl_wr && bus_wdata[TMR_LSB+i]) || $fell(cpu_present[i]))); // R10

        AST_ABSENT_QUIET: assert property (@(posedge clk) disable iff (rst)
            !cpu_present[i] |-> (!ipi_irq[i] && !timer_irq[i])); // R12

        AST_ABSENT_FROZEN: assert property (@(posedge clk) disable iff (rst)
            (!cpu_present[i] && !cnt_wr) |=> $stable(cnt_all[i])); // R12
    end
endmodule

bind irq_misc_reg irq_misc_chk #(
    .NCPU      (NCPU),
    .CNT_W     (CNT_W),
    .ADDR_W    (ADDR_W),
    .CTRL_ADDR (CTRL_ADDR),
    .CNT_BASE  (CNT_BASE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rd_cpu      (rd_cpu),
    .bus_rdata   (bus_rdata),
    .cpu_present (cpu_present),
    .ipi_irq     (ipi_irq),
    .timer_irq   (timer_irq),
    .ctrl_q      (ctrl_q),
    .cnt_all     (cnt_all)
);

// File: tb/irq_misc_reg_tb.sv
`timescale 1ns/1ps
module irq_misc_reg_tb;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr;
    logic [3:0]  bus_addr;
    logic [63:0] bus_wdata;
    logic [1:0]  rd_cpu;
    logic [63:0] bus_rdata;
    logic        tick;
    logic [3:0]  cpu_present;
    logic [3:0]  ipi_irq;
    logic [3:0]  timer_irq;

    always #2.5 clk = ~clk;

    irq_misc_reg u_dut (
        .clk         (clk),
        .rst         (rst),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .rd_cpu      (rd_cpu),
        .bus_rdata   (bus_rdata),
        .tick        (tick),
        .cpu_present (cpu_present),
        .ipi_irq     (ipi_irq),
        .timer_irq   (timer_irq)
    );

    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [63:0] m_ctrl;
    logic [24:0] m_cnt [4];
    logic        m_tick_prev;
    logic [3:0]  m_pres;

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mdl_write(input logic [63:0] c, input logic [63:0] w);
        logic [63:0] n;
        n = c & ~(w & 64'h1000_0FF0);
        if (w[20]) n = n & ~64'h00FF_0000;
        else begin
            n = n | (w & 64'h00F0_0000);
            if ((n & 64'h000F_0000) == 64'h0) n = n | (w & 64'h000F_0000);
        end
        n = n | ((w >> 4) & 64'h0F00);
        n = (n & ~64'h0000_0F00_0000_0000) | (w & 64'h0000_0F00_0000_0000);
        return n;
    endfunction

    task automatic mdl_tick();
        for (int i = 0; i < 4; i++) begin
            if (m_pres[i]) begin
                logic [24:0] nv;
                nv = (m_cnt[i] - 25'd1) | (m_cnt[i] & 25'h100_0000);
                m_cnt[i] = nv;
                if (nv[24]) m_ctrl[4+i] = 1'b1;
            end
        end
    endtask

    task automatic step(input bit wr, input logic [3:0] a,
                        input logic [63:0] d, input bit tk);
        bus_wr    = wr;
        bus_addr  = a;
        bus_wdata = d;
        tick      = tk;
        @(posedge clk);
        @(negedge clk);
        if (tk && !m_tick_prev) mdl_tick();
        if (wr) begin
            if (a == 4'd0) m_ctrl = mdl_write(m_ctrl, d);
            else if (a >= 4'd8 && a <= 4'd11) m_cnt[a-4'd8] = {1'b0, d[23:0]};
        end
        m_tick_prev = tk;
        bus_wr = 1'b0;
    endtask

    task automatic check_all(input string tag);
        for (int c = 0; c < 4; c++) begin
            rd_cpu   = 2'(c);
            bus_addr = 4'd0;
            #0.1;
            chk(tag, "control read", bus_rdata, m_ctrl | 64'(c));
        end
        for (int i = 0; i < 4; i++) begin
            bus_addr = 4'(8 + i);
            #0.1;
            chk(tag, "counter read", bus_rdata, {39'b0, m_cnt[i]});
        end
        bus_addr = 4'd1;
        #0.1;
        chk(tag, "unmapped read", bus_rdata, 64'h0);
        chk(tag, "ipi_irq", 64'(ipi_irq), 64'(m_ctrl[11:8] & m_pres));
        chk(tag, "timer_irq", 64'(timer_irq), 64'(m_ctrl[7:4] & m_pres));
    endtask

    initial begin
        #500_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
        rd_cpu = '0; tick = 1'b0; cpu_present = 4'hF;
        m_ctrl = 64'h0000_0008_0000_0000; m_tick_prev = 1'b0; m_pres = 4'hF;
        for (int i = 0; i < 4; i++) m_cnt[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // R2: writes to unmapped addresses change nothing
        step(1'b1, 4'd3,  '1, 1'b0);
        step(1'b1, 4'd15, '1, 1'b0);
        step(1'b1, 4'd12, '1, 1'b0);
        check_all("R2");

        // R6 / R3: request and clear interprocessor bits
        for (int v = 0; v < 16; v++) begin
            logic [3:0] cv;
            cv = {v[0], v[3:1]};
            step(1'b1, 4'd0, 64'(v) << 12, 1'b0);
            check_all("R6");
            step(1'b1, 4'd0, 64'(cv) << 8, 1'b0);
            check_all("R3");
        end
        // R6: set and clear of the same bit in one write
        step(1'b1, 4'd0, 64'h0000_F_F00, 1'b0);
        check_all("R6");
        step(1'b1, 4'd0, 64'h1000_0F00, 1'b0);
        check_all("R3");

        // R4 / R5: lock nibble and set-only nibble sweep
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                step(1'b1, 4'd0, 64'h0010_0000, 1'b0);
                check_all("R4");
                step(1'b1, 4'd0, (64'(a) << 16) | (64'(b & 14) << 20), 1'b0);
                step(1'b1, 4'd0, (64'(b) << 16) | (64'(a & 14) << 20), 1'b0);
                check_all("R5");
            end
        end

        // R7: read/write nibble and untouched bits
        step(1'b1, 4'd0, '1, 1'b0);
        check_all("R7");
        step(1'b1, 4'd0, 64'h0, 1'b0);
        check_all("R7");
        step(1'b1, 4'd0, 64'h0000_0A00_0000_0000, 1'b0);
        check_all("R7");

        // R8: counter writes keep 24 bits
        for (int i = 0; i < 4; i++) begin
            step(1'b1, 4'(8 + i), '1, 1'b0);
            check_all("R8");
        end

        // R9 / R10: tick countdown with small starts
        step(1'b1, 4'd8,  64'd0, 1'b0);
        step(1'b1, 4'd9,  64'd1, 1'b0);
        step(1'b1, 4'd10, 64'd2, 1'b0);
        step(1'b1, 4'd11, 64'd5, 1'b0);
        step(1'b1, 4'd0,  64'hF0, 1'b0);
        check_all("R10");
        for (int k = 0; k < 8; k++) begin
            step(1'b0, 4'd0, 64'h0, 1'b1);
            check_all("R9");
            step(1'b0, 4'd0, 64'h0, 1'b1);
            check_all("R9");
            step(1'b0, 4'd0, 64'h0, 1'b0);
            check_all("R10");
        end
        step(1'b1, 4'd0, 64'h50, 1'b0);
        check_all("R10");
        step(1'b0, 4'd0, 64'h0, 1'b0);
        check_all("R10");

        // R11: tick and write in the same cycle
        step(1'b1, 4'd0, 64'hF0, 1'b1);
        check_all("R11");
        step(1'b0, 4'd0, 64'h0, 1'b0);
        step(1'b1, 4'd9, 64'h123, 1'b1);
        check_all("R11");
        step(1'b0, 4'd0, 64'h0, 1'b0);

        // R12: an absent processor
        cpu_present = 4'b1011;
        m_pres      = 4'b1011;
        step(1'b1, 4'd10, 64'd3, 1'b0);
        step(1'b1, 4'd0,  64'hF0F0, 1'b0);
        check_all("R12");
        for (int k = 0; k < 5; k++) begin
            step(1'b0, 4'd0, 64'h0, 1'b1);
            check_all("R12");
            step(1'b0, 4'd0, 64'h0, 1'b0);
        end
        cpu_present = 4'hF;
        m_pres      = 4'hF;
        step(1'b0, 4'd0, 64'h0, 1'b0);
        check_all("R12");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule